// File: doc/BRIEF.md
# Quadrature Position Counter with Boundary Registers

This block turns two encoder phase pins and an index-style marker pin into a 32-bit signed position count. Each pin has its own polarity control and a two-flop synchroniser. An optional debounce filter can follow the synchroniser. A 3-bit mode field picks how the phase pins are read:
- gray-code quadrature,
- 2-bit binary,
- independent up and down pulses,
- pulse plus direction,
- a free-running timer steered by a direction level.

Two boundary registers, a low and a high one, sit beside the count. A 2-bit boundary mode decides what happens when the count meets them: report only, return to zero, capture on the marker, or let the boundary follow the count outward.

Software-side control comes as write-one-to-act command pulses and as plain configuration pins. The command pulses move values between the count, the boundaries and zero, and can arm a one-shot clear on the next marker edge. Eleven event sources are each gated by an enable bit into a sticky status vector. A status bit is cleared by a one-cycle pulse on the matching clear bit, and the interrupt output is high while any status bit is set. There is no data stream here, so all pins are plain level or pulse controls and none of them uses valid/ready.

Top module: `quad_pos_counter`

## Requirements
- R1: During and after reset, `count`, `min_val`, `max_val` and `status` are zero and `irq` is low.
- R2: Pin handling and debounce timing:
  - Each pin is XORed with its invert bit before anything else and then passes two synchroniser flops.
  - With `cfg_debounce_en` high, a new level is accepted only after it has been held for 2^`cfg_prescale` clocks, with the prescale limited to 17.
  - A shorter pulse is dropped.
- R3: Mode 0 (quadrature) steps the count on gray sequences of {a,b}:
  - The sequence 00→01→11→10→00 counts up by one per step, and the reverse order counts down.
  - A change of both phases at once leaves the count unchanged and raises status bit 0.
- R4: Mode 1 (binary) reads {a,b} as a 2-bit value with a as the MSB:
  - A change of +1 modulo 4 counts up and a change of −1 modulo 4 counts down.
  - A change of ±2 leaves the count unchanged and raises status bit 0.
- R5: Mode 2 (up/down) handles the phase pins as separate pulse inputs:
  - A rising edge on a alone counts up and a rising edge on b alone counts down.
  - Rising edges on both in the same cycle leave the count unchanged.
- R6: Modes 4 and 5 use b as the direction (b low counts up, b high counts down):
  - Mode 4 (direction counter) counts on each rising edge of a.
  - Mode 5 (direction timer) counts once on every clock while enabled.
- R7: With `cfg_enable` low, no phase step and no marker action changes the count. With `cfg_input_dis` high, the phase pins cause no step.
- R8: Counter load commands:
  - `cmd_bits[0]` loads the count with zero, `[2]` loads it from the low boundary and `[3]` from the high boundary.
  - Loads work while disabled.
  - A counter load wins over a step or marker clear in the same cycle.
- R9: Boundary load commands:
  - `cmd_bits[4]`, `[5]` and `[7]` load the low boundary with zero, the count or the high boundary.
  - `cmd_bits[8]`, `[9]` and `[10]` load the high boundary with zero, the count or the low boundary.
  - All sources are the values from before the edge, so bits 7 and 10 together swap the boundaries.
- R10: Marker pin behaviour:
  - A rising marker edge raises status bit 8. It raises bit 9 if a phase step occurs in the same cycle.
  - The edge zeroes the count and raises bit 10 when `cfg_zero_on_mark` is high, or once after `cmd_bits[12]` armed it. The arm is then released.
- R11: Boundary modes 1 and 2, with all comparisons signed:
  - In mode 1 (compare-and-zero), an up step reaching or passing the high boundary, or a down step reaching or passing the low boundary, loads zero instead.
  - In mode 2 (capture), a marker edge copies the count into the high boundary.
- R12: In boundary mode 3 (auto-extend), an up step beyond the high boundary moves it to the new count, and a down step below the low boundary moves it to the new count.
- R13: Status handling:
  - A status bit can only be set when its `irq_enable` bit is high.
  - It stays set until a pulse on its `stat_clear` bit, and a new event wins over a clear.
  - `irq` is high whenever any status bit is set.
  - The status bits, from bit 0 up, are: illegal code, up step, down step, low boundary hit, high boundary hit, bit-31 signed overflow, bit-15 signed overflow, step to zero, marker, marker error, marker clear.
- R14: Overflow and zero status:
  - Status bit 6 marks a step across the signed 16-bit limit of the low half, either up from 0x7FFF or down from 0x8000.
  - Bit 5 marks the same for the full count.
  - Bit 7 marks a step whose result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enables stepping and marker actions |
| cfg_debounce_en | input | 1 | Enables the debounce filter |
| cfg_prescale | input | 5 | Debounce stability exponent, 0..17 |
| cfg_inv_a | input | 1 | Inverts phase pin a |
| cfg_inv_b | input | 1 | Inverts phase pin b |
| cfg_inv_z | input | 1 | Inverts the marker pin |
| cfg_input_dis | input | 1 | Blocks steps from the phase pins |
| cfg_zero_on_mark | input | 1 | Every marker edge zeroes the count |
| cfg_mode | input | 3 | Count mode: 0 quad, 1 binary, 2 up/down, 4 dir count, 5 dir timer |
| cfg_bound | input | 2 | Boundary mode: 0 compare, 1 zero, 2 capture, 3 extend |
| cmd_bits | input | 13 | Write-one-to-act command pulse |
| irq_enable | input | 11 | Per-source status enable |
| stat_clear | input | 11 | Write-one-to-clear status pulse |
| pin_a | input | 1 | Phase a / up pin |
| pin_b | input | 1 | Phase b / down / direction pin |
| pin_z | input | 1 | Marker pin |
| count | output | 32 | Position count |
| min_val | output | 32 | Low boundary |
| max_val | output | 32 | High boundary |
| status | output | 11 | Sticky event status |
| irq | output | 1 | Any status bit set |

## Verification
Some properties are checked on every cycle:
- Status bits never drop without their clear bit.
- A status bit never rises while its enable bit is low.
- The count is frozen while disabled with no command.
- The boundaries only move under command, capture or extend.
- A zero-load command always yields zero.

Other behaviour depends on what the pins did and cannot be checked cycle by cycle, so only the directed scenarios show it:
- the decoding of each count mode, with gray, binary and illegal sequences;
- debounce rejection of short pulses;
- the swap through simultaneous boundary commands;
- the one-shot marker arm;
- compare-and-zero, capture and auto-extend;
- the 16-bit overflow flag.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int CMD_W = 13;
  localparam int NSRC  = 11;

  typedef enum logic [2:0] {
    MODE_QUAD   = 3'd0,
    MODE_BIN    = 3'd1,
    MODE_UPDN   = 3'd2,
    MODE_DIRCNT = 3'd4,
    MODE_DIRTMR = 3'd5
  } qpc_mode_e;

  typedef enum logic [1:0] {
    BND_COMPARE = 2'd0,
    BND_ZERO    = 2'd1,
    BND_CAPTURE = 2'd2,
    BND_EXTEND  = 2'd3
  } qpc_bound_e;

  // status / enable bit positions
  localparam int S_ILLEGAL = 0;
  localparam int S_UP      = 1;
  localparam int S_DOWN    = 2;
  localparam int S_MIN     = 3;
  localparam int S_MAX     = 4;
  localparam int S_OVHI    = 5;
  localparam int S_OV15    = 6;
  localparam int S_ZERO    = 7;
  localparam int S_MARK    = 8;
  localparam int S_MARKERR = 9;
  localparam int S_MARKCLR = 10;

  // command bit positions
  localparam int C_CNT_ZERO = 0;
  localparam int C_CNT_MIN  = 2;
  localparam int C_CNT_MAX  = 3;
  localparam int C_MIN_ZERO = 4;
  localparam int C_MIN_CNT  = 5;
  localparam int C_MIN_MAX  = 7;
  localparam int C_MAX_ZERO = 8;
  localparam int C_MAX_CNT  = 9;
  localparam int C_MAX_MIN  = 10;
  localparam int C_ARM      = 12;
endpackage

// File: rtl/qpc_input_cond.sv
module qpc_input_cond #(
  parameter int SYNC    = 2,
  parameter int PRE_W   = 5,
  parameter int MAX_PRE = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic             invert,
  input  logic             db_en,
  input  logic [PRE_W-1:0] prescale,
  output logic             level
);
  localparam int DB_W = MAX_PRE + 1;

  logic [SYNC-1:0]  sync_q;
  logic [DB_W-1:0]  stab_q;
  logic [PRE_W-1:0] pre_eff;
  logic [DB_W:0]    limit;
  logic             synced;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], pin_raw ^ invert};
  end

  assign synced  = sync_q[SYNC-1];
  assign pre_eff = (prescale > PRE_W'(MAX_PRE)) ? PRE_W'(MAX_PRE) : prescale;
  assign limit   = (DB_W+1)'(1) << pre_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level  <= 1'b0;
      stab_q <= '0;
    end else if (!db_en) begin
      level  <= synced;
      stab_q <= '0;
    end else if (synced == level) begin
      stab_q <= '0;
    end else if (({1'b0, stab_q} + (DB_W+1)'(1)) >= limit) begin
      level  <= synced;
      stab_q <= '0;
    end else begin
      stab_q <= stab_q + DB_W'(1);
    end
  end
endmodule

// File: rtl/qpc_step_decode.sv
module qpc_step_decode
  import qpc_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       active,
  input  logic       a,
  input  logic       b,
  input  logic       a_prev,
  input  logic       b_prev,
  output logic       step_up,
  output logic       step_dn,
  output logic       bad_code
);
  logic       ch_a, ch_b, rise_a, rise_b;
  logic [1:0] bin_diff;

  assign ch_a     = a ^ a_prev;
  assign ch_b     = b ^ b_prev;
  assign rise_a   = a & ~a_prev;
  assign rise_b   = b & ~b_prev;
  assign bin_diff = {a, b} - {a_prev, b_prev};

  always_comb begin
    step_up  = 1'b0;
    step_dn  = 1'b0;
    bad_code = 1'b0;
    if (active) begin
      case (mode)
        MODE_QUAD: begin
          if (ch_a && ch_b)     bad_code = 1'b1;
          else if (ch_a || ch_b) begin
            step_up = a_prev ^ b;
            step_dn = ~(a_prev ^ b);
          end
        end
        MODE_BIN: begin
          step_up  = (bin_diff == 2'd1);
          step_dn  = (bin_diff == 2'd3);
          bad_code = (bin_diff == 2'd2);
        end
        MODE_UPDN: begin
          step_up = rise_a & ~rise_b;
          step_dn = rise_b & ~rise_a;
        end
        MODE_DIRCNT: begin
          step_up = rise_a & ~b;
          step_dn = rise_a & b;
        end
        MODE_DIRTMR: begin
          step_up = ~b;
          step_dn = b;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int W     = 32,
  parameter int SYNC  = 2,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_debounce_en,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic             cfg_inv_a,
  input  logic             cfg_inv_b,
  input  logic             cfg_inv_z,
  input  logic             cfg_input_dis,
  input  logic             cfg_zero_on_mark,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_bound,
  input  logic [CMD_W-1:0] cmd_bits,
  input  logic [NSRC-1:0]  irq_enable,
  input  logic [NSRC-1:0]  stat_clear,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             pin_z,
  output logic [W-1:0]     count,
  output logic [W-1:0]     min_val,
  output logic [W-1:0]     max_val,
  output logic [NSRC-1:0]  status,
  output logic             irq
);
  localparam int NPIN = 3;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [NPIN-1:0] raw_pins, inv_bits, lvl;
  logic a_p, b_p, z_p, armed_q;
  logic up, dn, bad, upe, dne;
  logic z_evt, mark_clr, cnt_cmd, step_ok, max_hit, min_hit;
  logic [W-1:0] nxt_raw, step_val;
  logic [NSRC-1:0] evt;
  logic unused_cmd;

  assign raw_pins   = {pin_z, pin_b, pin_a};
  assign inv_bits   = {cfg_inv_z, cfg_inv_b, cfg_inv_a};
  assign unused_cmd = ^{cmd_bits[1], cmd_bits[6], cmd_bits[11]};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    qpc_input_cond #(.SYNC(SYNC), .PRE_W(PRE_W), .MAX_PRE(17)) u_cond (
      .clk(clk), .rst_n(rst_n), .pin_raw(raw_pins[i]), .invert(inv_bits[i]),
      .db_en(cfg_debounce_en), .prescale(cfg_prescale), .level(lvl[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) {z_p, b_p, a_p} <= '0;
    else        {z_p, b_p, a_p} <= lvl;
  end

  qpc_step_decode u_dec (
    .mode(cfg_mode), .active(cfg_enable & ~cfg_input_dis),
    .a(lvl[0]), .b(lvl[1]), .a_prev(a_p), .b_prev(b_p),
    .step_up(up), .step_dn(dn), .bad_code(bad)
  );

  assign z_evt    = cfg_enable & lvl[2] & ~z_p;
  assign mark_clr = z_evt & (cfg_zero_on_mark | armed_q);
  assign cnt_cmd  = cmd_bits[C_CNT_ZERO] | cmd_bits[C_CNT_MIN] | cmd_bits[C_CNT_MAX];
  assign step_ok  = ~cnt_cmd & ~mark_clr;
  assign upe      = up & step_ok;
  assign dne      = dn & step_ok;
  assign nxt_raw  = upe ? count + W'(1) : (dne ? count - W'(1) : count);
  assign max_hit  = upe & ($signed(nxt_raw) >= $signed(max_val));
  assign min_hit  = dne & ($signed(nxt_raw) <= $signed(min_val));
  assign step_val = ((cfg_bound == BND_ZERO) && (max_hit || min_hit)) ? '0 : nxt_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cmd_bits[C_CNT_ZERO]) begin
      count <= '0;
    end else if (cmd_bits[C_CNT_MIN]) begin
      count <= min_val;
    end else if (cmd_bits[C_CNT_MAX]) begin
      count <= max_val;
    end else if (mark_clr) begin
      count <= '0;
    end else begin
      count <= step_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      min_val <= '0;
    end else if (cmd_bits[C_MIN_ZERO]) begin
      min_val <= '0;
    end else if (cmd_bits[C_MIN_CNT]) begin
      min_val <= count;
    end else if (cmd_bits[C_MIN_MAX]) begin
      min_val <= max_val;
    end else if (cfg_bound == BND_EXTEND && min_hit) begin
      min_val <= nxt_raw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      max_val <= '0;
    end else if (cmd_bits[C_MAX_ZERO]) begin
      max_val <= '0;
    end else if (cmd_bits[C_MAX_CNT]) begin
      max_val <= count;
    end else if (cmd_bits[C_MAX_MIN]) begin
      max_val <= min_val;
    end else if (cfg_bound == BND_CAPTURE && z_evt) begin
      max_val <= count;
    end else if (cfg_bound == BND_EXTEND && max_hit) begin
      max_val <= nxt_raw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               armed_q <= 1'b0;
    else if (cmd_bits[C_ARM]) armed_q <= 1'b1;
    else if (z_evt)           armed_q <= 1'b0;
  end

  always_comb begin
    evt            = '0;
    evt[S_ILLEGAL] = bad;
    evt[S_UP]      = upe;
    evt[S_DOWN]    = dne;
    evt[S_MIN]     = min_hit;
    evt[S_MAX]     = max_hit;
    evt[S_OVHI]    = (upe && count == SMAX) || (dne && count == SMIN);
    evt[S_OV15]    = (upe && count[15:0] == 16'h7FFF) || (dne && count[15:0] == 16'h8000);
    evt[S_ZERO]    = (upe || dne) && (step_val == '0);
    evt[S_MARK]    = z_evt;
    evt[S_MARKERR] = z_evt & (up | dn);
    evt[S_MARKCLR] = mark_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~stat_clear) | (evt & irq_enable);
  end

  assign irq = |status;
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker
  import qpc_pkg::*;
#(
  parameter int W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic [1:0]       cfg_bound,
  input logic [CMD_W-1:0] cmd_bits,
  input logic [NSRC-1:0]  irq_enable,
  input logic [NSRC-1:0]  stat_clear,
  input logic [NSRC-1:0]  status,
  input logic [W-1:0]     count,
  input logic [W-1:0]     min_val,
  input logic [W-1:0]     max_val
);
  // R13
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(status) & ~$past(stat_clear)) & ~status) == '0));

  // R13
  status_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(irq_enable)) == '0));

  // R7
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && cmd_bits == '0) |=> $stable(count));

  // R9
  bounds_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bits == '0 && !cfg_bound[1]) |=> ($stable(min_val) && $stable(max_val)));

  // R8
  cnt_zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bits[C_CNT_ZERO] |=> (count == '0));
endmodule

bind quad_pos_counter qpc_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_bound(cfg_bound),
  .cmd_bits(cmd_bits), .irq_enable(irq_enable), .stat_clear(stat_clear),
  .status(status), .count(count), .min_val(min_val), .max_val(max_val)
);

// File: tb/quad_pos_counter_test.sv
`timescale 1ns/1ps
module quad_pos_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_debounce_en = 1'b0;
  logic [4:0] cfg_prescale = 5'd0;
  logic cfg_inv_a = 1'b0, cfg_inv_b = 1'b0, cfg_inv_z = 1'b0;
  logic cfg_input_dis = 1'b0, cfg_zero_on_mark = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [1:0] cfg_bound = 2'd0;
  logic [12:0] cmd_bits = '0;
  logic [10:0] irq_enable = 11'h7FF, stat_clear = '0;
  logic pin_a = 1'b0, pin_b = 1'b0, pin_z = 1'b0;
  logic [31:0] count, min_val, max_val;
  logic [10:0] status;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_pos_counter uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_debounce_en(cfg_debounce_en),
    .cfg_prescale(cfg_prescale), .cfg_inv_a(cfg_inv_a), .cfg_inv_b(cfg_inv_b),
    .cfg_inv_z(cfg_inv_z), .cfg_input_dis(cfg_input_dis), .cfg_zero_on_mark(cfg_zero_on_mark),
    .cfg_mode(cfg_mode), .cfg_bound(cfg_bound), .cmd_bits(cmd_bits),
    .irq_enable(irq_enable), .stat_clear(stat_clear), .pin_a(pin_a), .pin_b(pin_b),
    .pin_z(pin_z), .count(count), .min_val(min_val), .max_val(max_val),
    .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk); pin_a = a; pin_b = b; tick(6);
  endtask

  task automatic pulse_a();
    set_ab(1'b1, pin_b); set_ab(1'b0, pin_b);
  endtask

  task automatic pulse_b();
    set_ab(pin_a, 1'b1); set_ab(pin_a, 1'b0);
  endtask

  task automatic pulse_z();
    @(negedge clk); pin_z = 1'b1; tick(6);
    pin_z = 1'b0; tick(6);
  endtask

  task automatic cmd(input logic [12:0] bits);
    @(negedge clk); cmd_bits = bits;
    @(negedge clk); cmd_bits = '0;
  endtask

  task automatic clr_status();
    @(negedge clk); stat_clear = 11'h7FF;
    @(negedge clk); stat_clear = '0;
  endtask

  task automatic run_timer(input int n);
    @(negedge clk); cfg_enable = 1'b1;
    repeat (n) @(negedge clk);
    cfg_enable = 1'b0;
  endtask

  task automatic t_reset();
    tick(1);
    chk("R1 count", count, 0);
    chk("R1 min/max", {min_val[15:0], max_val[15:0]}, 0);
    chk("R1 status", {20'd0, irq, status}, 0);
    @(negedge clk); rst_n = 1'b1; cfg_enable = 1'b1;
    tick(4);
    chk("R1 after release", count, 0);
  endtask

  task automatic t_quad();
    cfg_mode = 3'd0;
    set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
    chk("R3 gray up", count, 4);
    set_ab(1, 0);
    chk("R3 gray down", count, 3);
    clr_status();
    set_ab(0, 1);
    chk("R3 both change count", count, 3);
    chk("R3 illegal status", {31'd0, status[0]}, 1);
  endtask

  task automatic t_binary();
    cfg_mode = 3'd1; cmd(13'h001); clr_status();
    set_ab(1, 0); set_ab(1, 1);
    chk("R4 binary up", count, 2);
    set_ab(0, 1);
    chk("R4 jump by two count", count, 2);
    chk("R4 jump illegal", {31'd0, status[0]}, 1);
    set_ab(0, 0);
    chk("R4 binary down", count, 1);
  endtask

  task automatic t_updown();
    cfg_mode = 3'd2; cmd(13'h001);
    pulse_a(); pulse_a(); pulse_a(); pulse_b();
    chk("R5 up/down pulses", count, 2);
    set_ab(1, 1); set_ab(0, 0);
    chk("R5 both rise", count, 2);
  endtask

  task automatic t_cond();
    cfg_debounce_en = 1'b1; cfg_prescale = 5'd3;
    @(negedge clk); pin_a = 1'b1; tick(4); pin_a = 1'b0; tick(20);
    chk("R2 short pulse dropped", count, 2);
    pin_a = 1'b1; tick(20); pin_a = 1'b0; tick(20);
    chk("R2 long pulse accepted", count, 3);
    cfg_debounce_en = 1'b0;
    @(negedge clk); cfg_inv_a = 1'b1; tick(8);
    chk("R2 invert rise counts", count, 4);
    cfg_inv_a = 1'b0; tick(8);
    chk("R2 invert fall no count", count, 4);
  endtask

  task automatic t_dir();
    cfg_mode = 3'd4; cmd(13'h001);
    pulse_a(); pulse_a();
    set_ab(0, 1); set_ab(1, 1); set_ab(0, 1);
    chk("R6 direction counter", count, 1);
    cfg_enable = 1'b0; cfg_mode = 3'd5; set_ab(0, 0); cmd(13'h001);
    run_timer(10);
    chk("R6 timer up", count, 10);
    set_ab(0, 1);
    run_timer(4);
    chk("R6 timer down", count, 6);
  endtask

  task automatic t_enable();
    cfg_mode = 3'd2; set_ab(0, 0);
    pulse_a();
    chk("R7 disabled ignores step", count, 6);
    cfg_enable = 1'b1; cfg_input_dis = 1'b1;
    pulse_a();
    chk("R7 input disable ignores step", count, 6);
    cfg_input_dis = 1'b0; cfg_enable = 1'b0;
  endtask

  task automatic t_cmd();
    cfg_mode = 3'd5; cmd(13'h001);
    run_timer(5); cmd(13'h200);
    chk("R9 max from count", max_val, 5);
    set_ab(0, 1); run_timer(12); cmd(13'h020);
    chk("R9 min from count", min_val, 32'hFFFF_FFF9);
    cmd(13'h008);
    chk("R8 count from max", count, 5);
    cmd(13'h004);
    chk("R8 count from min", count, 32'hFFFF_FFF9);
    cmd(13'h480);
    chk("R9 swap min", min_val, 5);
    chk("R9 swap max", max_val, 32'hFFFF_FFF9);
    cmd(13'h111);
    chk("R8 zero load", count, 0);
    chk("R9 zero loads", min_val | max_val, 0);
  endtask

  task automatic t_marker();
    set_ab(0, 0); run_timer(5);
    cfg_mode = 3'd2; cfg_enable = 1'b1; clr_status();
    pulse_z();
    chk("R10 marker no clear", count, 5);
    chk("R10 marker status", {31'd0, status[8]}, 1);
    cmd(13'h1000); pulse_z();
    chk("R10 armed clear", count, 0);
    chk("R10 clear status", {31'd0, status[10]}, 1);
    pulse_a(); pulse_a(); pulse_z();
    chk("R10 arm released", count, 2);
    cfg_zero_on_mark = 1'b1; pulse_z();
    chk("R10 zero every mark", count, 0);
    cfg_zero_on_mark = 1'b0; clr_status();
    @(negedge clk); pin_a = 1'b1; pin_z = 1'b1; tick(6);
    pin_a = 1'b0; pin_z = 1'b0; tick(6);
    chk("R10 marker error", {31'd0, status[9]}, 1);
    chk("R10 error step kept", count, 1);
  endtask

  task automatic t_bounds();
    cfg_enable = 1'b0; cfg_mode = 3'd5; set_ab(0, 0); cmd(13'h001);
    run_timer(3); cmd(13'h200);
    set_ab(0, 1); run_timer(5); cmd(13'h020); cmd(13'h001);
    cfg_bound = 2'd1; set_ab(0, 0); cfg_mode = 3'd2; cfg_enable = 1'b1; clr_status();
    pulse_a(); pulse_a(); pulse_a();
    chk("R11 zero at max", count, 0);
    chk("R11 max status", {31'd0, status[4]}, 1);
    pulse_b(); pulse_b();
    chk("R11 zero at min", count, 0);
    chk("R11 min status", {31'd0, status[3]}, 1);
    cfg_bound = 2'd2; pulse_a(); pulse_a(); pulse_z();
    chk("R11 capture into max", max_val, 2);
    cfg_bound = 2'd3; pulse_a();
    chk("R12 max extends", max_val, 3);
    cfg_enable = 1'b0; cfg_mode = 3'd5; set_ab(0, 1);
    run_timer(6);
    chk("R12 min extends", min_val, 32'hFFFF_FFFD);
    chk("R12 count below", count, 32'hFFFF_FFFD);
    cfg_bound = 2'd0;
  endtask

  task automatic t_status();
    cfg_mode = 3'd2; set_ab(0, 0); cfg_enable = 1'b1;
    clr_status(); irq_enable = 11'h002;
    pulse_a(); pulse_b();
    chk("R13 masked status", {20'd0, status}, 32'h002);
    chk("R13 irq high", {31'd0, irq}, 1);
    @(negedge clk); stat_clear = 11'h002;
    @(negedge clk); stat_clear = '0;
    chk("R13 cleared", {20'd0, irq, status}, 0);
    irq_enable = 11'h7FF; cfg_enable = 1'b0;
  endtask

  task automatic t_overflow();
    cfg_mode = 3'd5; set_ab(0, 0); cmd(13'h111); clr_status();
    run_timer(32768);
    chk("R14 count 0x8000", count, 32'h8000);
    chk("R14 bit15 overflow", {31'd0, status[6]}, 1);
    cmd(13'h001); set_ab(0, 1); run_timer(1);
    set_ab(0, 0); clr_status(); run_timer(1);
    chk("R14 step to zero", {31'd0, status[7]}, 1);
    chk("R14 count zero", count, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_quad();
    t_binary();
    t_updown();
    t_cond();
    t_dir();
    t_enable();
    t_cmd();
    t_marker();
    t_bounds();
    t_status();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule